// File: doc/BRIEF.md
# Full-Duplex Pause Flow Controller

This block runs link-level flow control for one full-duplex Ethernet port. It watches the port's receive-buffer fill level against two programmable levels with hysteresis. When the fill level climbs past the upper level it asks for a PAUSE frame carrying the maximum pause time. It keeps re-sending that frame at a fixed interval for as long as the port stays congested. Once the fill level drops under the lower level it sends a single PAUSE frame with a zero time, which lets the link partner resume. The frames leave as a byte stream that the downstream MAC pads with its FCS.

In the opposite direction, the block takes the decoded pause time of each received PAUSE frame and runs a pause timer in units of 512 bit times. While that timer is non-zero it raises a transmit-inhibit flag that holds back normal traffic. The inhibit flag only changes at a frame boundary. The block's own PAUSE frames are never inhibited.

The outgoing stream uses valid/ready. `tx_valid_o` stays high from the first byte to the last. A byte, and the valid flag with it, is held unchanged for as long as `tx_ready_i` is low. The stream moves one byte on every cycle in which both valid and ready are high. The ready input may stall the stream for any number of cycles. The source address must be stable whenever a frame starts. For the hysteresis to hold, the lower level must sit below the upper level. The recommended levels are 0x50 and 0x30, and they are provided as package constants.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `tx_inhibit_o`, `pause_req_o` and `tx_valid_o` are all low.
- R2: When the port is not congested and `occupancy_i` > `xoff_level_i`, the port becomes congested and one PAUSE frame with time 0xFFFF is requested. `pause_req_o` goes high one cycle later and stays high until that frame's last byte is accepted.
- R3: When the port is congested and `occupancy_i` < `xon_level_i`, the congestion is cleared and exactly one PAUSE frame with time 0x0000 is requested. A fill level between the two levels requests nothing.
- R4: While the port stays congested, another 0xFFFF frame is requested after every RESEND_TICKS_100 ticks at 100 Mb/s (`speed100_i`=1), or after every RESEND_TICKS_10 ticks at 10 Mb/s.
- R5: Each frame is 60 bytes, sent in this order: 01 80 C2 00 00 01; then the source address, most significant byte first; then 88 08 00 01; then the pause time, high byte first; then 42 bytes of zero.
- R6: While `tx_valid_o`=1 and `tx_ready_i`=0, the next cycle keeps `tx_valid_o`=1 and `tx_data_o` unchanged. The stream advances only on a handshake.
- R7: A received PAUSE with a non-zero time loads the pause timer. The pause time counts down in quanta of QUANTUM_TICKS_100 or QUANTUM_TICKS_10 ticks, chosen by speed. A PAUSE received while the timer is running reloads it. A received zero time clears it. The port is paused while the timer is non-zero.
- R8: `tx_inhibit_o` takes the paused state only in cycles where `frame_idle_i`=1, and otherwise holds its value.
- R9: A newly due frame replaces a request that has not started yet. A zero-time frame that becomes due while a 0xFFFF frame is streaming starts right after that frame completes.
- R10: With `enable_i`=0, no new frame starts, the pause timer and congestion state are cleared, and received PAUSE frames are ignored. A frame already streaming still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Flow-control enable |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| tick_i | input | 1 | Timebase tick, one per bit time at 100 Mb/s |
| occupancy_i | input | OCC_W | Buffer fill level |
| xoff_level_i | input | OCC_W | Upper (congestion) level |
| xon_level_i | input | OCC_W | Lower (release) level |
| src_addr_i | input | 48 | Local source address |
| rx_pause_valid_i | input | 1 | Pulse: a received PAUSE frame was decoded |
| rx_pause_time_i | input | 16 | Pause time of that frame |
| frame_idle_i | input | 1 | Transmit path is between frames |
| tx_ready_i | input | 1 | Downstream accepts a byte |
| tx_inhibit_o | output | 1 | Holds back normal frames |
| pause_req_o | output | 1 | A PAUSE frame is pending or streaming |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |

## Verification
Two events can land on the same cycle. In the first, a threshold crossing makes a new frame due while the generator is still streaming or is picking up the previous request. The bench provokes this by moving the fill level below the release level, and then above the congestion level again, during a 0xFFFF frame. It then checks that the pause times logged from the port form the sequence R9 predicts. In the second, a received PAUSE arrives while `frame_idle_i` is low. The bench raises and lowers the idle flag around the received PAUSE and checks cycle by cycle that the inhibit flag waits for the boundary. A behavioural reference model judges every output on every clock. Random back-pressure on `tx_ready_i` is applied during the resend phases.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int          FRAME_BYTES     = 60;
  localparam logic [15:0] XOFF_TIME       = 16'hFFFF;
  localparam logic [15:0] XON_TIME        = 16'h0000;
  localparam logic [7:0]  DEF_XOFF_LEVEL  = 8'h50;
  localparam logic [7:0]  DEF_XON_LEVEL   = 8'h30;
  localparam int          IDX_W           = $clog2(FRAME_BYTES);

  // byte at position idx of an outgoing PAUSE frame (FCS excluded)
  function automatic logic [7:0] pause_byte(input logic [IDX_W-1:0] idx,
                                            input logic [47:0] sa,
                                            input logic [15:0] ptime);
    logic [7:0] b;
    case (idx)
      6'd0:  b = 8'h01;
      6'd1:  b = 8'h80;
      6'd2:  b = 8'hC2;
      6'd3:  b = 8'h00;
      6'd4:  b = 8'h00;
      6'd5:  b = 8'h01;
      6'd6:  b = sa[47:40];
      6'd7:  b = sa[39:32];
      6'd8:  b = sa[31:24];
      6'd9:  b = sa[23:16];
      6'd10: b = sa[15:8];
      6'd11: b = sa[7:0];
      6'd12: b = 8'h88;
      6'd13: b = 8'h08;
      6'd14: b = 8'h00;
      6'd15: b = 8'h01;
      6'd16: b = ptime[15:8];
      6'd17: b = ptime[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/pfc_hyst.sv
module pfc_hyst
  import pfc_pkg::*;
#(
  parameter int OCC_W            = 8,
  parameter int RESEND_TICKS_100 = 4_200_000,
  parameter int RESEND_TICKS_10  = 42_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             speed100_i,
  input  logic             tick_i,
  input  logic [OCC_W-1:0] occupancy_i,
  input  logic [OCC_W-1:0] xoff_level_i,
  input  logic [OCC_W-1:0] xon_level_i,
  input  logic             take_i,
  output logic             pend_valid_o,
  output logic [15:0]      pend_time_o
);
  localparam int RS_MAX = (RESEND_TICKS_100 > RESEND_TICKS_10) ? RESEND_TICKS_100 : RESEND_TICKS_10;
  localparam int RS_W   = $clog2(RS_MAX + 1);
  localparam logic [RS_W-1:0] LIM100 = RS_W'(RESEND_TICKS_100 - 1);
  localparam logic [RS_W-1:0] LIM10  = RS_W'(RESEND_TICKS_10 - 1);

  logic            congested_q;
  logic [RS_W-1:0] resend_q;
  logic [RS_W-1:0] lim;
  logic            go_xoff, go_xon, resend_due;

  assign lim        = speed100_i ? LIM100 : LIM10;
  assign go_xoff    = !congested_q && (occupancy_i > xoff_level_i);
  assign go_xon     = congested_q && (occupancy_i < xon_level_i);
  assign resend_due = congested_q && !go_xon && tick_i && (resend_q >= lim);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      congested_q  <= 1'b0;
      resend_q     <= '0;
      pend_valid_o <= 1'b0;
      pend_time_o  <= XON_TIME;
    end else if (!enable_i) begin
      congested_q  <= 1'b0;
      resend_q     <= '0;
      pend_valid_o <= 1'b0;
    end else begin
      if (go_xoff) begin
        congested_q <= 1'b1;
        resend_q    <= '0;
      end else if (go_xon) begin
        congested_q <= 1'b0;
      end else if (congested_q && tick_i) begin
        resend_q <= resend_due ? '0 : resend_q + 1'b1;
      end
      // a new event overrides both a pending request and its pickup
      if (go_xoff || resend_due) begin
        pend_valid_o <= 1'b1;
        pend_time_o  <= XOFF_TIME;
      end else if (go_xon) begin
        pend_valid_o <= 1'b1;
        pend_time_o  <= XON_TIME;
      end else if (take_i) begin
        pend_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfc_tx_gen.sv
module pfc_tx_gen
  import pfc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        pend_valid_i,
  input  logic [15:0] pend_time_i,
  input  logic [47:0] src_addr_i,
  input  logic        tx_ready_i,
  output logic        take_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BYTES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      time_q;
  logic [47:0]      sa_q;

  assign take_o     = !busy_q && pend_valid_i && enable_i;
  assign tx_valid_o = busy_q;
  assign tx_data_o  = busy_q ? pause_byte(idx_q, sa_q, time_q) : 8'h00;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      time_q <= '0;
      sa_q   <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      time_q <= pend_time_i;
      sa_q   <= src_addr_i;
    end else if (busy_q && tx_ready_i) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfc_rx_timer.sv
module pfc_rx_timer #(
  parameter int QUANTUM_TICKS_100 = 512,
  parameter int QUANTUM_TICKS_10  = 5120
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        speed100_i,
  input  logic        tick_i,
  input  logic        rx_pause_valid_i,
  input  logic [15:0] rx_pause_time_i,
  input  logic        frame_idle_i,
  output logic        tx_inhibit_o
);
  localparam int Q_MAX = (QUANTUM_TICKS_100 > QUANTUM_TICKS_10) ? QUANTUM_TICKS_100 : QUANTUM_TICKS_10;
  localparam int Q_W   = $clog2(Q_MAX + 1);
  localparam logic [Q_W-1:0] QL100 = Q_W'(QUANTUM_TICKS_100 - 1);
  localparam logic [Q_W-1:0] QL10  = Q_W'(QUANTUM_TICKS_10 - 1);

  logic [15:0]    remain_q;
  logic [Q_W-1:0] qcnt_q;
  logic [Q_W-1:0] qlim;
  logic           paused;

  assign qlim   = speed100_i ? QL100 : QL10;
  assign paused = (remain_q != 16'd0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !enable_i) begin
      remain_q <= '0;
      qcnt_q   <= '0;
    end else if (rx_pause_valid_i) begin
      remain_q <= rx_pause_time_i;
      qcnt_q   <= '0;
    end else if (paused && tick_i) begin
      if (qcnt_q >= qlim) begin
        qcnt_q   <= '0;
        remain_q <= remain_q - 16'd1;
      end else begin
        qcnt_q <= qcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)           tx_inhibit_o <= 1'b0;
    else if (frame_idle_i) tx_inhibit_o <= paused;
  end
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int OCC_W             = 8,
  parameter int QUANTUM_TICKS_100 = 512,
  parameter int QUANTUM_TICKS_10  = 5120,
  parameter int RESEND_TICKS_100  = 4_200_000,
  parameter int RESEND_TICKS_10   = 42_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             speed100_i,
  input  logic             tick_i,
  input  logic [OCC_W-1:0] occupancy_i,
  input  logic [OCC_W-1:0] xoff_level_i,
  input  logic [OCC_W-1:0] xon_level_i,
  input  logic [47:0]      src_addr_i,
  input  logic             rx_pause_valid_i,
  input  logic [15:0]      rx_pause_time_i,
  input  logic             frame_idle_i,
  input  logic             tx_ready_i,
  output logic             tx_inhibit_o,
  output logic             pause_req_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o
);
  logic        pend_valid;
  logic [15:0] pend_time;
  logic        take;

  pfc_hyst #(
    .OCC_W(OCC_W), .RESEND_TICKS_100(RESEND_TICKS_100), .RESEND_TICKS_10(RESEND_TICKS_10)
  ) u_hyst (
    .clk_i, .rst_ni, .enable_i, .speed100_i, .tick_i, .occupancy_i,
    .xoff_level_i, .xon_level_i, .take_i(take),
    .pend_valid_o(pend_valid), .pend_time_o(pend_time)
  );

  pfc_tx_gen u_gen (
    .clk_i, .rst_ni, .enable_i, .pend_valid_i(pend_valid), .pend_time_i(pend_time),
    .src_addr_i, .tx_ready_i, .take_o(take), .tx_valid_o, .tx_data_o
  );

  pfc_rx_timer #(
    .QUANTUM_TICKS_100(QUANTUM_TICKS_100), .QUANTUM_TICKS_10(QUANTUM_TICKS_10)
  ) u_rx (
    .clk_i, .rst_ni, .enable_i, .speed100_i, .tick_i, .rx_pause_valid_i,
    .rx_pause_time_i, .frame_idle_i, .tx_inhibit_o
  );

  assign pause_req_o = pend_valid | tx_valid_o;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        rx_pause_valid_i,
  input logic [15:0] rx_pause_time_i,
  input logic        frame_idle_i,
  input logic        tx_ready_i,
  input logic        tx_inhibit_o,
  input logic        tx_valid_o,
  input logic [7:0]  tx_data_o
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R6
  AST_INHIBIT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_idle_i |=> $stable(tx_inhibit_o)); // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !tx_valid_o |=> !tx_valid_o); // R10
  AST_PAUSE_TAKES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && rx_pause_valid_i && (rx_pause_time_i != 16'd0) ##1 frame_idle_i
    |=> tx_inhibit_o); // R7
  AST_ZERO_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && rx_pause_valid_i && (rx_pause_time_i == 16'd0) ##1 frame_idle_i
    |=> !tx_inhibit_o); // R7
endmodule

bind pause_flow_ctrl pfc_checker i_chk (.*);

// File: tb/test_pause_flow_ctrl.sv
`timescale 1ns/1ps
module test_pause_flow_ctrl;
  localparam int Q100 = 4, Q10 = 8, RS100 = 300, RS10 = 600;
  localparam logic [47:0] SA = 48'h0A1B2C3D4E5F;

  logic clk = 0, rst_n = 0, en = 0, spd = 1, tick = 0;
  logic [7:0] occ = 0, xoff_l = 8'h50, xon_l = 8'h30;
  logic rxv = 0, idle = 1, rdy = 1;
  logic [15:0] rxt = 0;
  logic inh, preq, vld;
  logic [7:0] dat;

  int checks = 0, fails = 0;
  bit rand_rdy = 0, done = 0;
  int dut_times[$];
  int pos = 0, hi = 0;

  always #5 clk = ~clk;

  pause_flow_ctrl #(.OCC_W(8), .QUANTUM_TICKS_100(Q100), .QUANTUM_TICKS_10(Q10),
    .RESEND_TICKS_100(RS100), .RESEND_TICKS_10(RS10)) i_pause_flow_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .speed100_i(spd), .tick_i(tick),
    .occupancy_i(occ), .xoff_level_i(xoff_l), .xon_level_i(xon_l), .src_addr_i(SA),
    .rx_pause_valid_i(rxv), .rx_pause_time_i(rxt), .frame_idle_i(idle), .tx_ready_i(rdy),
    .tx_inhibit_o(inh), .pause_req_o(preq), .tx_valid_o(vld), .tx_data_o(dat));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cong = 0, m_pv = 0, m_pt = 0, m_rs = 0, m_rem = 0, m_qc = 0, m_inh = 0;
  bit m_busy = 0;
  int m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cong = 0; m_pv = 0; m_pt = 0; m_rs = 0; m_rem = 0; m_qc = 0; m_inh = 0;
      m_busy = 0; m_q.delete();
    end else begin
      int old_rem, lim, qlim;
      bit start, xoff_ev, xon_ev, rs_ev;
      old_rem = m_rem;
      lim  = spd ? RS100 : RS10;
      qlim = spd ? Q100 : Q10;
      start = !m_busy && (m_pv != 0) && en;
      if (m_busy && rdy) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_busy = 0;
      end
      if (start) begin
        int sa_b[6];
        for (int k = 0; k < 6; k++) sa_b[k] = (SA >> (8 * (5 - k))) & 8'hFF;
        m_q = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
        for (int k = 0; k < 6; k++) m_q.push_back(sa_b[k]);
        m_q.push_back(8'h88); m_q.push_back(8'h08); m_q.push_back(8'h00); m_q.push_back(8'h01);
        m_q.push_back((m_pt >> 8) & 8'hFF); m_q.push_back(m_pt & 8'hFF);
        for (int k = 0; k < 42; k++) m_q.push_back(0);
        m_busy = 1;
      end
      if (!en) begin
        m_cong = 0; m_pv = 0; m_rs = 0;
      end else begin
        xoff_ev = (m_cong == 0) && (occ > xoff_l);
        xon_ev  = (m_cong != 0) && (occ < xon_l);
        rs_ev   = 0;
        if (xoff_ev) begin m_cong = 1; m_rs = 0; end
        else if (xon_ev) m_cong = 0;
        else if (m_cong != 0 && tick) begin
          if (m_rs >= lim - 1) begin rs_ev = 1; m_rs = 0; end else m_rs++;
        end
        if (xoff_ev || rs_ev) begin m_pv = 1; m_pt = 16'hFFFF; end
        else if (xon_ev) begin m_pv = 1; m_pt = 0; end
        else if (start) m_pv = 0;
      end
      if (!en) begin m_rem = 0; m_qc = 0; end
      else if (rxv) begin m_rem = rxt; m_qc = 0; end
      else if (m_rem != 0 && tick) begin
        if (m_qc >= qlim - 1) begin m_qc = 0; m_rem--; end else m_qc++;
      end
      if (idle) m_inh = (old_rem != 0);
    end
  end

  // per-cycle comparison and frame logging, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(inh == m_inh[0], "R7/R8 tx_inhibit", inh, m_inh);
      chk(preq == ((m_pv != 0) || m_busy), "R2/R3 pause_req", preq, (m_pv != 0) || m_busy);
      chk(vld == m_busy, "R6 tx_valid", vld, m_busy);
      if (vld && m_busy) chk(dat == m_q[0][7:0], "R5 tx_data", dat, m_q[0]);
      if (vld && rdy) begin
        if (pos == 16) hi = dat;
        if (pos == 17) dut_times.push_back((hi << 8) | dat);
        pos = (pos == 59) ? 0 : pos + 1;
      end
    end
  end

  initial begin : tick_gen
    int n = 0;
    forever begin
      @(posedge clk); #2;
      tick = (n % 3 == 0);
      n++;
    end
  end

  initial begin : ready_gen
    forever begin
      @(posedge clk); #2;
      if (rand_rdy) rdy = ($urandom % 2) != 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_times(input string req, input int exp[$]);
    chk(dut_times.size() == exp.size(), req, dut_times.size(), exp.size());
    for (int k = 0; k < exp.size() && k < dut_times.size(); k++)
      chk(dut_times[k] == exp[k], req, dut_times[k], exp[k]);
    dut_times.delete();
  endtask

  initial begin : stim
    cyc(5);
    chk(!inh && !preq && !vld, "R1 reset state", {inh, preq, vld}, 0);
    rst_n = 1; en = 1; occ = 8'h20;
    cyc(10);
    chk(!preq, "R3 below levels no request", preq, 0);
    // R2 / R3: rise, middle band, release
    occ = 8'h60; cyc(1);
    chk(preq, "R2 request one cycle after crossing", preq, 1);
    cyc(150);
    occ = 8'h40; cyc(50);
    chk(!preq, "R3 middle band requests nothing", preq, 0);
    occ = 8'h10; cyc(150);
    expect_times("R2 R3 xoff then xon", '{32'hFFFF, 32'h0});
    // R4: resend at 100 Mb/s with random back-pressure (R6)
    rand_rdy = 1;
    occ = 8'h60; cyc(2000);
    occ = 8'h10; cyc(300);
    expect_times("R4 resend at 100M", '{32'hFFFF, 32'hFFFF, 32'hFFFF, 32'h0});
    // R4 at 10 Mb/s
    spd = 0;
    occ = 8'h60; cyc(2000);
    occ = 8'h10; cyc(300);
    expect_times("R4 resend at 10M", '{32'hFFFF, 32'hFFFF, 32'h0});
    rand_rdy = 0; rdy = 1; spd = 1; cyc(5);
    // R9: xon due mid-xoff follows; then an unstarted xon replaced by xoff
    occ = 8'h60; cyc(10);
    occ = 8'h10; cyc(200);
    occ = 8'h60; cyc(10);
    occ = 8'h10; cyc(3);
    occ = 8'h60; cyc(200);
    occ = 8'h10; cyc(200);
    expect_times("R9 ordering and replacement", '{32'hFFFF, 32'h0, 32'hFFFF, 32'hFFFF, 32'h0});
    // R7: load, reload, zero
    rxv = 1; rxt = 16'd3; cyc(1); rxv = 0; cyc(3);
    chk(inh, "R7 inhibit after nonzero pause", inh, 1);
    rxv = 1; rxt = 16'd5; cyc(1); rxv = 0; cyc(45);
    chk(inh, "R7 reload extends pause", inh, 1);
    rxv = 1; rxt = 16'd0; cyc(1); rxv = 0; cyc(3);
    chk(!inh, "R7 zero pause releases", inh, 0);
    rxv = 1; rxt = 16'd2; cyc(1); rxv = 0; cyc(40);
    chk(!inh, "R7 timer expiry releases", inh, 0);
    // R8: change waits for frame boundary
    idle = 0;
    rxv = 1; rxt = 16'd2; cyc(1); rxv = 0; cyc(5);
    chk(!inh, "R8 no change mid-frame", inh, 0);
    idle = 1; cyc(2);
    chk(inh, "R8 change at boundary", inh, 1);
    cyc(60);
    // R10: disabled
    en = 0;
    rxv = 1; rxt = 16'd9; cyc(1); rxv = 0; cyc(4);
    chk(!inh, "R10 received pause ignored", inh, 0);
    occ = 8'h60; cyc(60);
    chk(!preq && !vld, "R10 no request while disabled", {preq, vld}, 0);
    occ = 8'h10; en = 1; cyc(10);
    occ = 8'h60; cyc(100);
    en = 0; occ = 8'h10; cyc(100);
    expect_times("R10 no xon after disable", '{32'hFFFF});
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule